// File: doc/BRIEF.md
# Battery Charge-Cycle and Learning-Age Counters

This block counts battery charge cycles. A charge integrator upstream hands it discharged-charge increments. The block adds them into an internal accumulator. Each time the accumulated discharge reaches one design capacity, it credits one cycle. A design capacity is 256 times the capacity unit supplied on `cap_unit`. The excess above the capacity stays in the accumulator.

Every credited cycle advances two saturating 16-bit counters:

- a lifetime count, which only a full reset clears;
- an age count, which restarts whenever a capacity-learning cycle completes.

When the age count reaches 32, the block raises a flag saying that the learned capacity is no longer trustworthy. The flag stays up until the next learning cycle or a full reset. Both counts leave the block as read-only low/high byte pairs.

Top module: `cycle_tally`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both counts read 0 and `cap_stale` reads 0.
- R2: In a cycle with `dsg_vld` high, `dsg_amt` is added to the accumulator. When the sum is greater than or equal to 256 × `cap_unit`, one cycle is credited and the capacity is subtracted, keeping the remainder. Both counts show the credit after the next rising edge. A sum exactly equal to the capacity credits a cycle and leaves 0.
- R3: At most one cycle is credited per clock. Any remainder still at or above the capacity is credited on following clocks, one per clock, even when no increment arrives.
- R4: The age count advances on every clock on which the lifetime count is credited.
- R5: A `learn_done` pulse clears the age count and `cap_stale` at the next edge. It takes priority over a credit in the same cycle. The lifetime count still takes that credit.
- R6: `cap_stale` goes to 1 on the same edge on which the age count reaches 32. It then stays 1, however many more credits arrive, until it is cleared.
- R7: `full_rst` high clears the accumulator, both counts and `cap_stale` at the next edge. It overrides any credit or learning pulse in that cycle.
- R8: Both counts stop at 0xFFFF instead of wrapping.
- R9: While `cap_unit` is 0, no cycle is ever credited.
- R10: Each `*_lo` port carries bits 7:0 of its count, and each `*_hi` port carries bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_rst | input | 1 | Synchronous clear of all cycle state |
| learn_done | input | 1 | One-cycle pulse: a capacity-learning cycle completed |
| dsg_vld | input | 1 | `dsg_amt` is valid this cycle |
| dsg_amt | input | 16 | Discharged-charge increment, in capacity units / 256 |
| cap_unit | input | 16 | Design capacity unit; capacity = 256 × this |
| total_lo | output | 8 | Lifetime cycle count, low byte |
| total_hi | output | 8 | Lifetime cycle count, high byte |
| age_lo | output | 8 | Cycles since learning, low byte |
| age_hi | output | 8 | Cycles since learning, high byte |
| cap_stale | output | 1 | Learned capacity stale (age reached 32) |

## Verification
A wrong remainder in the accumulator cannot be seen directly. It shows up as a credit one or more clocks too early or too late, so the lifetime count is off by one on the clock after the faulty sum. A lost or doubled carry shows up over the next few idle clocks as a wrong number of drain credits. A disagreement between the age count and `cap_stale`, or a missed clear, is visible on the edge right after the crossing of 32 or after the learning pulse. The bench therefore compares every port against a behavioural model on every clock.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int CAP_SHFT = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic stale;
    } flag_st_t;
endpackage

// File: rtl/dsg_accum.sv
module dsg_accum #(
    parameter int INC_W    = 16,
    parameter int CAP_W    = 16,
    parameter int CAP_SHFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_vld,
    input  logic [INC_W-1:0] inc_amt,
    input  logic [CAP_W-1:0] cap_unit,
    output logic             credit
);
    localparam int CAPF_W = CAP_W + CAP_SHFT;
    localparam int ACC_W  = ((CAPF_W > INC_W) ? CAPF_W : INC_W) + 2;
    localparam logic [ACC_W:0] ACC_MAX = {1'b0, {ACC_W{1'b1}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W:0]   sum_wide;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] cap_full;
    logic             cap_zero;

    always_comb begin
        cap_full = ACC_W'({cap_unit, {CAP_SHFT{1'b0}}});
        cap_zero = (cap_unit == '0);
        sum_wide = {1'b0, st_q.acc}
                 + ((ACC_W+1)'(inc_vld ? inc_amt : '0));
        // clamp instead of wrapping when input outpaces credits
        sum      = (sum_wide > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : sum_wide[ACC_W-1:0];
        credit   = !cap_zero && (sum >= cap_full);
        st_d     = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (credit) begin
            st_d.acc = sum - cap_full;
        end else begin
            st_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a zero capacity never credits
    a_r9_no_credit_zero_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_unit == '0) |-> !credit);

    // R2: with no input and no credit the remainder is held
    a_r2_hold_remainder: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc_vld && !credit) |=> $stable(st_q.acc));

    // R7: clear empties the accumulator
    a_r7_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.acc == '0));
endmodule

// File: rtl/sat_ctr.sv
module sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] val;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.val = '0;
        end else if (step && (st_q.val != TOP)) begin
            st_d.val = st_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

    // R8: a count at the top stays there
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (q == TOP)) |=> (q == TOP));

    // R3: never more than one step per clock
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q == $past(q)) || (q == $past(q) + 1'b1)));
endmodule

// File: rtl/cycle_tally.sv
module cycle_tally
    import cyc_pkg::*;
#(
    parameter int INC_W    = 16,
    parameter int CAP_W    = 16,
    parameter int CI_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_rst,
    input  logic              learn_done,
    input  logic              dsg_vld,
    input  logic [INC_W-1:0]  dsg_amt,
    input  logic [CAP_W-1:0]  cap_unit,
    output logic [BYTE_W-1:0] total_lo,
    output logic [BYTE_W-1:0] total_hi,
    output logic [BYTE_W-1:0] age_lo,
    output logic [BYTE_W-1:0] age_hi,
    output logic              cap_stale
);
    localparam cnt_t LIMIT     = cnt_t'(CI_LIMIT);
    localparam cnt_t LIMIT_M1  = cnt_t'(CI_LIMIT - 1);
    localparam cnt_t CNT_TOP   = {CNT_W{1'b1}};

    logic     credit;
    cnt_t     total_q;
    cnt_t     age_q;
    logic     age_clr;
    flag_st_t fl_d, fl_q;

    assign age_clr = full_rst || learn_done;

    dsg_accum #(
        .INC_W   (INC_W),
        .CAP_W   (CAP_W),
        .CAP_SHFT(CAP_SHFT)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (full_rst),
        .inc_vld (dsg_vld),
        .inc_amt (dsg_amt),
        .cap_unit(cap_unit),
        .credit  (credit)
    );

    sat_ctr #(.W(CNT_W)) u_total (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (full_rst),
        .step (credit),
        .q    (total_q)
    );

    sat_ctr #(.W(CNT_W)) u_age (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (age_clr),
        .step (credit),
        .q    (age_q)
    );

    always_comb begin
        fl_d = fl_q;
        if (age_clr) begin
            fl_d.stale = 1'b0;
        end else if (credit && (age_q == LIMIT_M1)) begin
            fl_d.stale = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign total_lo  = total_q[BYTE_W-1:0];
    assign total_hi  = total_q[CNT_W-1:BYTE_W];
    assign age_lo    = age_q[BYTE_W-1:0];
    assign age_hi    = age_q[CNT_W-1:BYTE_W];
    assign cap_stale = fl_q.stale;

    // R6: flag and age count agree on every clock
    a_r6_flag_matches_age: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.stale == (age_q >= LIMIT));

    // R5: learning clears age and flag
    a_r5_learn_clears: assert property (@(posedge clk) disable iff (!rst_n)
        learn_done |=> ((age_q == '0) && !fl_q.stale));

    // R7: full reset clears every count
    a_r7_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst |=> ((total_q == '0) && (age_q == '0) && !fl_q.stale));

    // R4: age never rises without the lifetime count rising or sitting at the top
    a_r4_age_with_total: assert property (@(posedge clk) disable iff (!rst_n)
        !age_clr |=> ((age_q == $past(age_q)) || (total_q == $past(total_q) + 1'b1)
                      || (total_q == CNT_TOP)));
endmodule

// File: tb/sim_cycle_tally.sv
module sim_cycle_tally;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        full_rst = 1'b0;
    logic        learn_done = 1'b0;
    logic        dsg_vld = 1'b0;
    logic [15:0] dsg_amt = '0;
    logic [15:0] cap_unit = '0;
    logic [7:0]  total_lo, total_hi, age_lo, age_hi;
    logic        cap_stale;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    longint m_acc = 0;
    longint m_tot = 0;
    longint m_age = 0;
    bit     m_flag = 0;
    localparam longint ACCMAX = (64'd1 << 26) - 1;

    always #10 clk = ~clk;

    cycle_tally u0 (
        .clk(clk), .rst_n(rst_n), .full_rst(full_rst), .learn_done(learn_done),
        .dsg_vld(dsg_vld), .dsg_amt(dsg_amt), .cap_unit(cap_unit),
        .total_lo(total_lo), .total_hi(total_hi), .age_lo(age_lo), .age_hi(age_hi),
        .cap_stale(cap_stale)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 0; m_tot = 0; m_age = 0; m_flag = 0;
        end else begin
            longint s;
            longint capf;
            bit cr;
            capf = longint'(cap_unit) * 256;
            s = m_acc + (dsg_vld ? longint'(dsg_amt) : 0);
            if (s > ACCMAX) s = ACCMAX;
            cr = (cap_unit != 0) && (s >= capf);
            if (full_rst) begin
                m_acc = 0; m_tot = 0; m_age = 0; m_flag = 0;
            end else begin
                if (cr) begin
                    s = s - capf;
                    if (m_tot < 65535) m_tot = m_tot + 1;
                end
                m_acc = s;
                if (learn_done) begin
                    m_age = 0; m_flag = 0;
                end else if (cr) begin
                    if (m_age < 65535) m_age = m_age + 1;
                    if (m_age >= 32) m_flag = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic cmp_model();
        chk("R2 total", {total_hi, total_lo}, m_tot);
        chk("R4 age", {age_hi, age_lo}, m_age);
        chk("R6 flag", cap_stale, m_flag);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        cmp_model();
    endtask

    task automatic idle();
        dsg_vld = 0; learn_done = 0; full_rst = 0;
    endtask

    task automatic feed(input int amt, input int n);
        for (int i = 0; i < n; i++) begin
            dsg_vld = 1; dsg_amt = 16'(amt);
            tick();
        end
        dsg_vld = 0;
    endtask

    function automatic longint tot();
        return longint'({total_hi, total_lo});
    endfunction

    function automatic longint age();
        return longint'({age_hi, age_lo});
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 total in reset", tot(), 0);
        chk("R1 flag in reset", cap_stale, 0);
        rst_n = 1;
        tick();
        chk("R1 age after reset", age(), 0);

        // R2: capacity 1024, remainder kept
        cap_unit = 4;
        feed(300, 3);
        chk("R2 below capacity", tot(), 0);
        feed(300, 1);
        chk("R2 crossing capacity", tot(), 1);
        feed(848, 1);
        chk("R2 exact capacity", tot(), 2);
        feed(1023, 1);
        chk("R2 remainder zero after exact", tot(), 2);

        // R3: large carry drains one per clock
        full_rst = 1; tick(); full_rst = 0;
        chk("R7 cleared", tot(), 0);
        cap_unit = 1;
        feed(1000, 1);
        chk("R3 first credit", tot(), 1);
        tick();
        chk("R3 drain credit 2", tot(), 2);
        tick();
        chk("R3 drain credit 3", tot(), 3);
        tick();
        chk("R3 drain stops", tot(), 3);

        // R9: zero capacity
        cap_unit = 0;
        feed(5000, 4);
        chk("R9 no credit", tot(), 3);
        full_rst = 1; tick(); full_rst = 0;
        cap_unit = 1;

        // R6: flag at 32
        feed(256, 31);
        chk("R6 age 31", age(), 31);
        chk("R6 flag low at 31", cap_stale, 0);
        feed(256, 1);
        chk("R6 flag at 32", cap_stale, 1);
        feed(256, 5);
        chk("R6 flag sticky", cap_stale, 1);

        // R5: learning pulse alone, then with a credit
        learn_done = 1; tick(); learn_done = 0;
        chk("R5 age cleared", age(), 0);
        chk("R5 flag cleared", cap_stale, 0);
        chk("R5 total kept", tot(), 37);
        learn_done = 1; dsg_vld = 1; dsg_amt = 256; tick(); idle();
        chk("R5 priority age", age(), 0);
        chk("R5 total still credited", tot(), 38);

        // R7: full reset beats credit and learning
        full_rst = 1; learn_done = 1; dsg_vld = 1; dsg_amt = 256; tick(); idle();
        chk("R7 total", tot(), 0);
        chk("R7 age", age(), 0);
        tick();
        chk("R7 accumulator empty", tot(), 0);

        // R10: byte split at 300
        feed(256, 300);
        chk("R10 total_hi", total_hi, 1);
        chk("R10 total_lo", total_lo, 44);
        chk("R10 age_lo", age_lo, 44);

        // R8: saturation
        feed(256, 65300);
        chk("R8 total top", tot(), 65535);
        chk("R8 age top", age(), 65535);
        feed(256, 3);
        chk("R8 total held", tot(), 65535);
        chk("R8 flag held", cap_stale, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule